// File: doc/BRIEF.md
# SMBus Line-State Supervisor

This block sits beside the serial engine of an SMBus slave and watches only the two bus lines. It does not shift bits or decode commands. It turns long-lasting line states into events that the rest of the device acts on:

- A clock held low too long ends the current transfer.
- Both lines resting high for a long time resets any transfer that is half done.
- Both lines resting low for a while asks for an offset calibration.
- Both lines low for a very long time puts the interface into a bus-off state.

All intervals are measured in ticks of a free-running 1 ms strobe.

Each raw line passes through a two-flop synchronizer and then a tick-based deglitcher. A change on a line is accepted only after it has lasted for two ticks. The interval counters look only at these filtered lines. Event outputs are single-cycle pulses. The bus-off and bus-available outputs are levels. After bus-off ends, the bus-available flag comes back on the next tick.

Top module: `smbus_line_supervisor`

## Requirements
- R1: After reset, bus_off is 0, bus_avail is 1 and the three pulse outputs are 0.
- R2: A change on either line is accepted only after it has lasted for two ticks. A low glitch on SCL that lasts one tick period does not restart the both-high idle interval.
- R3: When filtered SCL stays low for the effective timeout (in ticks), timeout_pulse fires once. A low span 3 ticks shorter than the timeout gives no pulse.
- R4: The effective timeout is cfg_timeout_ticks limited to the range 25 to 35. Values below 25 act as 25 and values above 35 act as 35.
- R5: When both lines stay high for more than 50 ticks, idle_reset_pulse fires once. A high span of 47 ticks gives none.
- R6: While cfg_idle_off is 1, idle_reset_pulse never fires.
- R7: When both lines stay low for cfg_cal_ticks ticks (a value of 0 acts as 1), cal_req_pulse fires. It fires exactly once per continuous low span, however long that span lasts.
- R8: When both lines stay low for 2000 ticks, bus_off goes to 1 and bus_avail goes to 0. The two flags are never 1 together.
- R9: bus_off clears as soon as either filtered line is high. bus_avail returns to 1 on the first tick after bus_off clears.
- R10: timeout_pulse, idle_reset_pulse and cal_req_pulse are each high for exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe every 1 ms |
| scl_in | input | 1 | Raw SMBus clock line level |
| sda_in | input | 1 | Raw SMBus data line level |
| cfg_timeout_ticks | input | 6 | Clock-low timeout in ticks, limited to 25..35 |
| cfg_idle_off | input | 1 | When 1, disables the idle reset event |
| cfg_cal_ticks | input | 16 | Both-low interval in ticks before a calibration request |
| timeout_pulse | output | 1 | Clock-low timeout event |
| idle_reset_pulse | output | 1 | Long both-high idle event |
| cal_req_pulse | output | 1 | Offset calibration request |
| bus_off | output | 1 | Bus-off state level |
| bus_avail | output | 1 | Bus available level |

## Verification
A counter that fails to clear when its line condition breaks shows up at the ports as an event that fires early, or fires twice within one bus episode. The bench brings this out by holding lines for spans 3 ticks on either side of each threshold. A deglitcher that passes short pulses moves the idle event later by roughly 30 ticks, and a check within a 56-tick window catches that. A stuck bus-off or bus-available flag is visible within four ticks of the lines rising. A pulse that stays high for more than one cycle is caught because the bench counts every high cycle of each pulse output.

// File: rtl/smb_sup_pkg.sv
package smb_sup_pkg;
  localparam int TO_W   = 6;
  localparam int TO_MIN = 25;
  localparam int TO_MAX = 35;
  localparam int CAL_W  = 16;

  function automatic logic [TO_W-1:0] clamp_timeout(input logic [TO_W-1:0] cfg);
    if (cfg < TO_W'(TO_MIN)) return TO_W'(TO_MIN);
    if (cfg > TO_W'(TO_MAX)) return TO_W'(TO_MAX);
    return cfg;
  endfunction

  function automatic logic [CAL_W-1:0] cal_limit(input logic [CAL_W-1:0] cfg);
    return (cfg == '0) ? CAL_W'(1) : cfg;
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_TICKS = 2,
  localparam int CW = $clog2(FILT_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  logic [1:0]    sync_q;
  logic [CW-1:0] agree_cnt;
  logic          sync_line;
  logic          differs;

  assign sync_line = sync_q[1];
  assign differs   = sync_line != filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      filt      <= 1'b1;
      agree_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (!differs) begin
        agree_cnt <= '0;
      end else if (tick) begin
        if (agree_cnt == CW'(FILT_TICKS - 1)) begin
          filt      <= sync_line;
          agree_cnt <= '0;
        end else begin
          agree_cnt <= agree_cnt + CW'(1);
        end
      end
    end
  end

  // R2
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> $past(tick));
  // R2
  filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> (filt == $past(sync_line)));
endmodule

// File: rtl/smb_span_counter.sv
module smb_span_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         active,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         hit
);
  localparam logic [W-1:0] SAT = '1;
  logic at_sat;

  assign at_sat = count == SAT;
  assign hit    = tick && active && !at_sat && ((count + W'(1)) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (!active)          count <= '0;
    else if (tick && !at_sat)  count <= count + W'(1);
  end

  // R10
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
  // R7
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == '0 || count == $past(count) + W'(1)));
  // R3
  hit_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> active);
endmodule

// File: rtl/smbus_line_supervisor.sv
module smbus_line_supervisor
  import smb_sup_pkg::*;
#(
  parameter int FILT_TICKS   = 2,
  parameter int IDLE_TICKS   = 50,
  parameter int BUSOFF_TICKS = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [TO_W-1:0]  cfg_timeout_ticks,
  input  logic             cfg_idle_off,
  input  logic [CAL_W-1:0] cfg_cal_ticks,
  output logic             timeout_pulse,
  output logic             idle_reset_pulse,
  output logic             cal_req_pulse,
  output logic             bus_off,
  output logic             bus_avail
);
  localparam int LINES  = 2;
  localparam int IDLE_W = $clog2(IDLE_TICKS + 2) + 1;

  logic [LINES-1:0] raw_lines, filt_lines;
  logic             scl_f, sda_f, both_low, both_high;
  logic [TO_W-1:0]  to_count;
  logic [IDLE_W-1:0] idle_count;
  logic [CAL_W-1:0] low_count;
  logic             to_hit, idle_hit, cal_hit, busoff_hit;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    smb_line_filter #(.FILT_TICKS(FILT_TICKS)) i_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .raw(raw_lines[g]), .filt(filt_lines[g]));
  end

  assign scl_f     = filt_lines[0];
  assign sda_f     = filt_lines[1];
  assign both_low  = !scl_f && !sda_f;
  assign both_high = scl_f && sda_f;

  smb_span_counter #(.W(TO_W)) i_to_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(!scl_f),
    .limit(clamp_timeout(cfg_timeout_ticks)), .count(to_count), .hit(to_hit));

  smb_span_counter #(.W(IDLE_W)) i_idle_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(both_high),
    .limit(IDLE_W'(IDLE_TICKS + 1)), .count(idle_count), .hit(idle_hit));

  smb_span_counter #(.W(CAL_W)) i_low_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(both_low),
    .limit(cal_limit(cfg_cal_ticks)), .count(low_count), .hit(cal_hit));

  assign busoff_hit = tick && both_low && (low_count == CAL_W'(BUSOFF_TICKS - 1));

  assign timeout_pulse    = to_hit;
  assign idle_reset_pulse = idle_hit && !cfg_idle_off;
  assign cal_req_pulse    = cal_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_off   <= 1'b0;
      bus_avail <= 1'b1;
    end else begin
      if (busoff_hit) begin
        bus_off   <= 1'b1;
        bus_avail <= 1'b0;
      end else begin
        if (!both_low) bus_off <= 1'b0;
        if (tick && !bus_off && !bus_avail) bus_avail <= 1'b1;
      end
    end
  end

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_off && bus_avail));
  // R3
  timeout_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> !scl_f);
  // R7
  cal_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_pulse |-> both_low);
  // R6
  idle_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_reset_pulse |-> !cfg_idle_off);
  // R9
  busoff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_off) |-> $past(!both_low));
  // R9
  avail_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_avail) |-> ($past(tick) && $past(!bus_off)));
endmodule

// File: tb/test_smbus_line_supervisor.sv
module test_smbus_line_supervisor;
  logic clk = 0, rst_n = 0, tick = 0, scl = 1, sda = 1;
  logic [5:0]  cfg_to = 6'd30;
  logic        cfg_idle_off = 0;
  logic [15:0] cfg_cal = 16'd100;
  logic to_p, idle_p, cal_p, boff, bavail;
  int checks = 0, fails = 0;
  int to_rise, idle_rise, cal_rise, to_hi, idle_hi, cal_hi;
  logic to_d, idle_d, cal_d;

  always #2.5 clk = ~clk;

  smbus_line_supervisor i_smbus_line_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scl_in(scl), .sda_in(sda),
    .cfg_timeout_ticks(cfg_to), .cfg_idle_off(cfg_idle_off), .cfg_cal_ticks(cfg_cal),
    .timeout_pulse(to_p), .idle_reset_pulse(idle_p), .cal_req_pulse(cal_p),
    .bus_off(boff), .bus_avail(bavail));

  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  end

  always @(negedge clk) begin
    if (to_p) to_hi++;
    if (idle_p) idle_hi++;
    if (cal_p) cal_hi++;
    if (to_p && !to_d) to_rise++;
    if (idle_p && !idle_d) idle_rise++;
    if (cal_p && !cal_d) cal_rise++;
    to_d = to_p; idle_d = idle_p; cal_d = cal_p;
  end

  function automatic int exp_timeout(input int cfg);
    return (cfg < 25) ? 25 : (cfg > 35) ? 35 : cfg;
  endfunction

  task automatic clr();
    to_rise = 0; idle_rise = 0; cal_rise = 0; to_hi = 0; idle_hi = 0; cal_hi = 0;
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge tick);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_width();
    chk(to_hi == to_rise, "R10 timeout width", to_hi, to_rise);
    chk(idle_hi == idle_rise, "R10 idle width", idle_hi, idle_rise);
    chk(cal_hi == cal_rise, "R10 cal width", cal_hi, cal_rise);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int unsigned seed;
    int thr, len;
    bit longer;
    to_d = 0; idle_d = 0; cal_d = 0;
    clr();
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(boff == 0, "R1 bus_off", boff, 0);
    chk(bavail == 1, "R1 bus_avail", bavail, 1);
    chk({to_p, idle_p, cal_p} == 3'b0, "R1 pulses", {to_p, idle_p, cal_p}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 glitch filter during idle
    scl = 0; sda = 0; wt(6);
    clr(); scl = 1; sda = 1;
    wt(30);
    scl = 0; repeat (4) @(negedge clk); scl = 1;
    wt(26);
    chk(idle_rise == 1, "R2 glitch ignored by idle", idle_rise, 1);
    chk(to_rise == 0, "R2 glitch no timeout", to_rise, 0);

    // R5 idle below threshold
    scl = 0; sda = 0; wt(6);
    clr(); scl = 1; sda = 1; wt(47);
    scl = 0; sda = 0; wt(5);
    chk(idle_rise == 0, "R5 idle short", idle_rise, 0);
    // R5 idle above threshold, long hold stays single
    clr(); scl = 1; sda = 1; wt(120);
    chk(idle_rise == 1, "R5 idle long", idle_rise, 1);
    // R6 idle disabled
    cfg_idle_off = 1;
    scl = 0; sda = 0; wt(6);
    clr(); scl = 1; sda = 1; wt(90);
    chk(idle_rise == 0, "R6 idle disabled", idle_rise, 0);
    cfg_idle_off = 0;

    // R3 R4 timeout with random config
    for (int i = 0; i < 16; i++) begin
      cfg_to = 6'($urandom_range(0, 63));
      if (i == 0) cfg_to = 6'd5;
      if (i == 1) cfg_to = 6'd60;
      thr = exp_timeout(int'(cfg_to));
      longer = $urandom_range(0, 1);
      len = longer ? thr + 3 + int'($urandom_range(0, 20)) : thr - 3;
      scl = 1; sda = 1; wt(4);
      clr(); scl = 0; wt(len);
      scl = 1; wt(4);
      chk(to_rise == (longer ? 1 : 0), $sformatf("R3 R4 timeout cfg=%0d len=%0d", cfg_to, len),
          to_rise, longer ? 1 : 0);
      chk_width();
    end

    // R7 calibration request
    for (int i = 0; i < 10; i++) begin
      cfg_cal = 16'($urandom_range(10, 200));
      if (i == 0) cfg_cal = 16'd0;
      thr = (cfg_cal == 0) ? 1 : int'(cfg_cal);
      longer = (i == 0) ? 1'b1 : 1'($urandom_range(0, 1));
      len = longer ? thr + 3 + int'($urandom_range(0, 2 * thr)) : thr - 3;
      scl = 1; sda = 1; wt(4);
      clr(); scl = 0; sda = 0; wt(len);
      scl = 1; sda = 1; wt(4);
      chk(cal_rise == (longer ? 1 : 0), $sformatf("R7 cal thr=%0d len=%0d", thr, len),
          cal_rise, longer ? 1 : 0);
      chk_width();
    end

    // R8 R9 bus-off
    cfg_cal = 16'd100;
    scl = 1; sda = 1; wt(4);
    clr(); scl = 0; sda = 0; wt(1997);
    chk(boff == 0, "R8 bus_off before limit", boff, 0);
    chk(bavail == 1, "R8 avail before limit", bavail, 1);
    wt(9);
    chk(boff == 1, "R8 bus_off set", boff, 1);
    chk(bavail == 0, "R8 avail cleared", bavail, 0);
    chk(cal_rise == 1, "R7 cal once over long low", cal_rise, 1);
    sda = 1; wt(4);
    chk(boff == 0, "R9 bus_off cleared", boff, 0);
    chk(bavail == 1, "R9 avail returned", bavail, 1);
    // R9 clear via SCL
    scl = 0; sda = 0; wt(2010);
    chk(boff == 1, "R8 bus_off set again", boff, 1);
    scl = 1; wt(4);
    chk(boff == 0 && bavail == 1, "R9 cleared by scl", {boff, bavail}, 1);
    chk_width();
    summary();
  end
endmodule